// File: doc/BRIEF.md
# Two-Level Virtual Page Map

This block translates the page field of a 32-bit virtual address into a physical page through two chained lookups. The upper eleven page bits (23..13) index a 2048-entry directory of 5-bit block numbers. The block number, joined with the five lower page bits (12..8), indexes a 1024-entry table of 24-bit page entries. The low 14 bits of the selected entry, followed by the byte offset in address bits 7..0, form a 22-bit physical address.

The map input is taken from either of two 32-bit operands. One is the address register, which is used when a memory cycle starts. The other is the data register, which is used for data-type lookups and for every map write. A start strobe sends its translation into an output hold register. That register keeps the physical address steady until the next start reaches it. The directory value and the raw page entry are both visible at the ports, along with a flag for an empty directory slot, so that a miss in either level can be identified.

Map writes use the data register as the map address and the address register as the write data. A write to the second level lands in the slot that the current directory content selects for that address.

Top module: `page_map_2lvl`

## Requirements
- R1: While `rst_n` is low, `phys_addr`, `lvl2_entry` and `lvl1_val` are all zero and `lvl1_miss` is 1.
- R2: Map-input bits 23..13 presented in cycle n select the directory slot whose 5-bit value appears on `lvl1_val` after the clock edge that ends cycle n.
- R3: `lvl2_entry` shows, one edge after `lvl1_val`, the 24-bit entry at second-level index {directory value, map-input bits 12..8}, with the directory value in the upper five index bits.
- R4: `sel_vma` = 1 takes the map input from `vma_in`, and `sel_vma` = 0 takes it from `md_in`. Bits 31..24 of the map input have no effect on the translation.
- R5: When `start` is high in cycle n, `phys_addr` after edge n+3 equals {`lvl2_entry`[13:0] from that lookup, `vma_in`[7:0] of cycle n}. The offset always comes from `vma_in`, whichever operand is selected.
- R6: `phys_addr` keeps its value through every edge that does not capture a start, whatever the other inputs do.
- R7: `lvl1_miss` is 1 exactly when `lvl1_val` is zero.
- R8: `wr_lvl1` in cycle n writes `vma_in`[4:0] to the directory slot addressed by `md_in`[23:13]. Lookups presented from cycle n+1 onward see the new value. The other `vma_in` bits are ignored.
- R9: `wr_lvl2` in cycle n, with `sel_vma` = 0, writes `vma_in`[23:0] to the second-level slot {directory[`md_in`[23:13]], `md_in`[12:8]}. Lookups presented from cycle n+1 onward see the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| vma_in | input | 32 | Address register operand: map input when selected, offset source, and write data |
| md_in | input | 32 | Data register operand: map input when selected, and write address |
| sel_vma | input | 1 | 1 selects vma_in as the map input, 0 selects md_in |
| start | input | 1 | Begins a memory cycle; its translation is captured in the hold register |
| wr_lvl1 | input | 1 | Writes one directory slot |
| wr_lvl2 | input | 1 | Writes one second-level entry |
| phys_addr | output | 22 | Held physical address {page[13:0], offset[7:0]} |
| lvl2_entry | output | 24 | Raw second-level entry of the current lookup |
| lvl1_val | output | 5 | Directory value of the current lookup |
| lvl1_miss | output | 1 | Directory value is zero |

## Verification
A lookup presented in cycle n has three results, each due at a different edge. The directory value is due after edge n+1, the page entry after edge n+2, and the held physical address after edge n+3. The bench drives each lookup one time unit after an edge. It then waits exactly one, two and three edges, sampling each result just after the edge where it becomes due.

Once the start has been dropped, the bench changes the operands. This shows that later results follow the captured lookup and not the live inputs. Writes are followed at once, in the next cycle, by the lookup that must observe them, which pins down the earliest cycle in which each write becomes visible.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
   localparam int PMAP_VA_W     = 32;
   localparam int PMAP_OFF_W    = 8;
   localparam int PMAP_PG_W     = 5;
   localparam int PMAP_DIR_W    = 11;
   localparam int PMAP_BLK_W    = 5;
   localparam int PMAP_ENT_W    = 24;
   localparam int PMAP_PPAGE_W  = 14;

   // Join a page entry's frame bits with a byte offset.
   function automatic logic [PMAP_PPAGE_W+PMAP_OFF_W-1:0] pmap_join
      (input logic [PMAP_PPAGE_W-1:0] frame, input logic [PMAP_OFF_W-1:0] off);
      return {frame, off};
   endfunction
endpackage

// File: rtl/pmap_ram.sv
module pmap_ram #(
   parameter int AW        = 11,
   parameter int DW        = 5,
   parameter bit OUT_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || DW < 1) begin : g_bad_geom
      $error("pmap_ram: AW and DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // Read-first: a same-edge write is seen by the following read.
   if (OUT_RESET) begin : g_rst_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= mem[raddr];
      end
   end else begin : g_plain_out
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) rdata <= mem[raddr];
   end
endmodule

// File: rtl/pmap_hold_reg.sv
module pmap_hold_reg #(
   parameter int W = 22
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("pmap_hold_reg: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/page_map_2lvl.sv
module page_map_2lvl
   import pmap_pkg::*;
#(
   parameter int VA_W    = PMAP_VA_W,
   parameter int OFF_W   = PMAP_OFF_W,
   parameter int PG_W    = PMAP_PG_W,
   parameter int DIR_W   = PMAP_DIR_W,
   parameter int BLK_W   = PMAP_BLK_W,
   parameter int ENT_W   = PMAP_ENT_W,
   parameter int PPAGE_W = PMAP_PPAGE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [VA_W-1:0]          vma_in,
   input  logic [VA_W-1:0]          md_in,
   input  logic                     sel_vma,
   input  logic                     start,
   input  logic                     wr_lvl1,
   input  logic                     wr_lvl2,
   output logic [PPAGE_W+OFF_W-1:0] phys_addr,
   output logic [ENT_W-1:0]         lvl2_entry,
   output logic [BLK_W-1:0]         lvl1_val,
   output logic                     lvl1_miss
);
   localparam int PG_LSB  = OFF_W;
   localparam int DIR_LSB = OFF_W + PG_W;
   localparam int TOP_BIT = DIR_LSB + DIR_W;
   localparam int L2_AW   = BLK_W + PG_W;
   localparam int PA_W    = PPAGE_W + OFF_W;

   if (TOP_BIT > VA_W) begin : g_bad_split
      $error("page_map_2lvl: address fields exceed VA_W");
   end
   if (PPAGE_W > ENT_W) begin : g_bad_frame
      $error("page_map_2lvl: frame wider than entry");
   end
   if (BLK_W > VA_W || ENT_W > VA_W) begin : g_bad_data
      $error("page_map_2lvl: write data wider than operand");
   end

   // Map input selection.
   logic [VA_W-1:0] map_in;
   assign map_in = sel_vma ? vma_in : md_in;

   // First level: lookup from map input, write addressed by md_in.
   pmap_ram #(.AW(DIR_W), .DW(BLK_W), .OUT_RESET(1'b1)) u_dir (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_lvl1),
      .waddr (md_in[DIR_LSB +: DIR_W]),
      .wdata (vma_in[BLK_W-1:0]),
      .raddr (map_in[DIR_LSB +: DIR_W]),
      .rdata (lvl1_val)
   );

   // Stage one: carry the rest of the lookup alongside the directory read.
   logic [PG_W-1:0]  pg_s1;
   logic [OFF_W-1:0] off_s1;
   logic [ENT_W-1:0] wd_s1;
   logic             cap_s1;
   logic             wr2_s1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_s1  <= '0;
         off_s1 <= '0;
         wd_s1  <= '0;
         cap_s1 <= 1'b0;
         wr2_s1 <= 1'b0;
      end else begin
         pg_s1  <= map_in[PG_LSB +: PG_W];
         off_s1 <= vma_in[OFF_W-1:0];
         wd_s1  <= vma_in[ENT_W-1:0];
         cap_s1 <= start;
         wr2_s1 <= wr_lvl2;
      end
   end

   // Second level: indexed by directory value above the low page bits.
   logic [L2_AW-1:0] l2_idx;
   assign l2_idx = {lvl1_val, pg_s1};

   pmap_ram #(.AW(L2_AW), .DW(ENT_W), .OUT_RESET(1'b1)) u_ent (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr2_s1),
      .waddr (l2_idx),
      .wdata (wd_s1),
      .raddr (l2_idx),
      .rdata (lvl2_entry)
   );

   // Stage two: offset and capture strobe meet the entry.
   logic [OFF_W-1:0] off_s2;
   logic             cap_s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_s2 <= '0;
         cap_s2 <= 1'b0;
      end else begin
         off_s2 <= off_s1;
         cap_s2 <= cap_s1;
      end
   end

   logic [PA_W-1:0] pa_next;
   assign pa_next = pmap_join(lvl2_entry[PPAGE_W-1:0], off_s2);

   pmap_hold_reg #(.W(PA_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cap_s2),
      .d     (pa_next),
      .q     (phys_addr)
   );

   assign lvl1_miss = (lvl1_val == '0);

   logic unused_bits;
   assign unused_bits = ^{map_in[VA_W-1:TOP_BIT], map_in[OFF_W-1:0],
                          lvl2_entry[ENT_W-1:PPAGE_W]};
endmodule

// File: rtl/page_map_2lvl_chk.sv
module page_map_2lvl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] vma_in,
   input logic [31:0] md_in,
   input logic        sel_vma,
   input logic        start,
   input logic        wr_lvl1,
   input logic [21:0] phys_addr,
   input logic [23:0] lvl2_entry,
   input logic [4:0]  lvl1_val,
   input logic        cap_s2
);
   // R1: outputs cleared while reset is held
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (phys_addr == '0 && lvl1_val == '0 && lvl2_entry == '0));

   // R5: offset bits come from vma_in of the start cycle
   a_r5_offset: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ##2 (phys_addr[7:0] == $past(vma_in[7:0], 3)));

   // R5: frame bits come from the entry of the started lookup
   a_r5_frame: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ##2 (phys_addr[21:8] == $past(lvl2_entry[13:0])));

   // R6: no capture, no change
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_s2 |=> $stable(phys_addr));

   // R8: directory write visible to a lookup of the same slot one cycle later
   a_r8_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lvl1 ##1 (!sel_vma && md_in[23:13] == $past(md_in[23:13]))
      |=> (lvl1_val == $past(vma_in[4:0], 2)));
endmodule

bind page_map_2lvl page_map_2lvl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vma_in     (vma_in),
   .md_in      (md_in),
   .sel_vma    (sel_vma),
   .start      (start),
   .wr_lvl1    (wr_lvl1),
   .phys_addr  (phys_addr),
   .lvl2_entry (lvl2_entry),
   .lvl1_val   (lvl1_val),
   .cap_s2     (cap_s2)
);

// File: tb/page_map_2lvl_bench.sv
`timescale 1ns/100ps
module page_map_2lvl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [31:0] vma_in = '0;
   logic [31:0] md_in = '0;
   logic        sel_vma = 1'b0;
   logic        start = 1'b0;
   logic        wr_lvl1 = 1'b0;
   logic        wr_lvl2 = 1'b0;
   logic [21:0] phys_addr;
   logic [23:0] lvl2_entry;
   logic [4:0]  lvl1_val;
   logic        lvl1_miss;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   page_map_2lvl u_page_map_2lvl (
      .clk(clk), .rst_n(rst_n), .vma_in(vma_in), .md_in(md_in),
      .sel_vma(sel_vma), .start(start), .wr_lvl1(wr_lvl1), .wr_lvl2(wr_lvl2),
      .phys_addr(phys_addr), .lvl2_entry(lvl2_entry), .lvl1_val(lvl1_val),
      .lvl1_miss(lvl1_miss)
   );

   // {dir index[10:0], low page[4:0], directory value[4:0], entry[23:0]}
   localparam logic [44:0] VEC [6] = '{
      {11'h000, 5'h00, 5'h01, 24'hA53C1F},
      {11'h7FF, 5'h1F, 5'h1F, 24'h123456},
      {11'h2AA, 5'h15, 5'h0A, 24'hFFFFFF},
      {11'h555, 5'h0A, 5'h15, 24'h000001},
      {11'h123, 5'h07, 5'h01, 24'h3FC0DE},
      {11'h400, 5'h10, 5'h10, 24'h802000}
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put_dir(input logic [10:0] idx, input logic [4:0] val);
      md_in   = {8'h5A, idx, 13'h1ABC};
      vma_in  = {27'h7FFFFE0 ^ 27'h0123456, val};
      sel_vma = 1'b0;
      wr_lvl1 = 1'b1;
      tick();
      wr_lvl1 = 1'b0;
   endtask

   task automatic put_ent(input logic [10:0] idx, input logic [4:0] pg, input logic [23:0] data);
      md_in   = {8'hC3, idx, pg, 8'h77};
      vma_in  = {8'hE1, data};
      sel_vma = 1'b0;
      wr_lvl2 = 1'b1;
      tick();
      wr_lvl2 = 1'b0;
   endtask

   task automatic look(input bit use_md, input logic [10:0] idx, input logic [4:0] pg,
                       input logic [7:0] off, input logic [4:0] exp_dir,
                       input logic [23:0] exp_ent, input bit full, input string sfx);
      logic [31:0] a;
      a = {8'h9D ^ {3'b0, pg}, idx, pg, off};
      if (use_md) begin
         md_in   = a;
         vma_in  = {8'h00, ~idx, ~pg, off};
         sel_vma = 1'b0;
      end else begin
         vma_in  = a;
         md_in   = ~a;
         sel_vma = 1'b1;
      end
      start = 1'b1;
      tick();
      start  = 1'b0;
      vma_in = ~vma_in;
      md_in  = ~md_in;
      chk({"R2 dir value ", sfx}, {27'b0, lvl1_val}, {27'b0, exp_dir});
      chk({"R7 miss flag ", sfx}, {31'b0, lvl1_miss}, {31'b0, exp_dir == 5'd0});
      tick();
      if (full) chk({"R3 entry ", sfx}, {8'b0, lvl2_entry}, {8'b0, exp_ent});
      tick();
      if (full) chk({"R5 phys ", sfx}, {10'b0, phys_addr}, {10'b0, exp_ent[13:0], off});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [21:0] held;
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 phys in reset", {10'b0, phys_addr}, 32'h0);
      chk("R1 entry in reset", {8'b0, lvl2_entry}, 32'h0);
      chk("R1 dir in reset", {27'b0, lvl1_val}, 32'h0);
      chk("R1 miss in reset", {31'b0, lvl1_miss}, 32'h1);
      rst_n = 1'b1;
      tick();

      // Table walk: R8 write, R9 write, then lookups (R2 R3 R4 R5)
      for (int i = 0; i < 6; i++) begin
         logic [44:0] v;
         v = VEC[i];
         put_dir(v[44:34], v[28:24]);
         put_ent(v[44:34], v[33:29], v[23:0]);
      end
      for (int i = 0; i < 6; i++) begin
         logic [44:0] v;
         v = VEC[i];
         look(1'b0, v[44:34], v[33:29], 8'(i * 37 + 5), v[28:24], v[23:0], 1'b1, "R4 vma path");
      end

      // R6: operands churn without start, phys must hold
      held = phys_addr;
      for (int k = 0; k < 4; k++) begin
         vma_in = 32'hDEAD0000 + 32'(k);
         md_in  = 32'hBEEF0000 - 32'(k);
         sel_vma = k[0];
         tick();
      end
      chk("R6 hold no start", {10'b0, phys_addr}, {10'b0, held});

      // R4: lookup through md_in, offset still from vma_in
      look(1'b1, VEC[1][44:34], VEC[1][33:29], 8'hC4, VEC[1][28:24], VEC[1][23:0], 1'b1, "R4 md path");

      // R7: empty directory slot
      put_dir(11'h0F0, 5'd0);
      look(1'b0, 11'h0F0, 5'h03, 8'h11, 5'd0, 24'h0, 1'b0, "R7 empty slot");

      // R9: overwrite an entry, next-cycle lookup must see it
      put_ent(VEC[2][44:34], VEC[2][33:29], 24'h5A5A5A);
      look(1'b0, VEC[2][44:34], VEC[2][33:29], 8'h3E, VEC[2][28:24], 24'h5A5A5A, 1'b1, "R9 rewrite");

      // R8: redirect a directory slot to another block
      put_ent(VEC[4][44:34], VEC[3][33:29], 24'h0C0FFE);
      put_dir(VEC[3][44:34], 5'h01);
      look(1'b0, VEC[3][44:34], VEC[3][33:29], 8'h99, 5'h01, 24'h0C0FFE, 1'b1, "R8 redirect");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule